// File: doc/BRIEF.md
# One-Step Correction Field Updater

This block does the arithmetic for one-step precision time transmit. A frame leaving the port carries a 64-bit signed correction value in units of 2^-16 ns. The block adds to that value the time the frame spent inside the node, which is the egress timestamp minus the ingress timestamp. It also adds a signed per-port latency trim. Timestamps and the trim are in units of 2^-8 ns, so their sum is scaled by 256 before the addition.

Overflow of the 64-bit signed field follows one of three policies, selected by a 2-bit mode:
- plain two's-complement wrap;
- clamping to the signed limits;
- a hint-driven policy. Bits [1:0] of the incoming field say whether to wrap, and which sign the field really had. In this policy the low byte of the field is ignored on input and zeroed on output.

When one-step operation is off, the field is passed through untouched. Parsing the frame, patching checksums and writing the field back into the frame are handled elsewhere.

The result is registered. A valid strobe accompanies each result one clock after the input strobe.

Top module: `cf_updater`

## Requirements
- R1: With `step_en` low, a valid input produces `cf_out` equal to `cf_in` unchanged, whatever the mode.
- R2: With `step_en` high and mode 2'b00, `cf_out` = `cf_in` + 256 × ((`ts_egress` − `ts_ingress`) + sign-extended `lat_adj`), taken modulo 2^64. `cf_out[7:0]` equals `cf_in[7:0]` in this mode.
- R3: In mode 2'b00, overflow wraps. For example, `cf_in` = 0x7FFFFFFF_FFFFFF00 with a residence of one unit and zero trim gives 0x80000000_00000000.
- R4: In mode 2'b01, a result above the signed maximum becomes 0x7FFFFFFF_FFFFFFFF, and a result below the signed minimum becomes 0x80000000_00000000. Otherwise the result is the same as in R2.
- R5: In mode 2'b10, the sum is formed from `cf_in` with its bits [7:0] treated as zero, and `cf_out[7:0]` is always zero.
- R6: In mode 2'b10 with `cf_in[0]` = 1, an overflowing sum wraps modulo 2^64.
- R7: In mode 2'b10 with `cf_in[0]` = 0, an overflowing sum is replaced by 0x7FFFFFFF_FFFFFF00 when `cf_in[1]` = 0, and by 0x80000000_00000000 when `cf_in[1]` = 1.
- R8: Mode 2'b11 gives the same result as mode 2'b00.
- R9: `out_valid` is `in_valid` delayed by one clock. `cf_out` changes only in the cycle after a valid input and otherwise holds its value.
- R10: After reset, `out_valid` is 0 and `cf_out` is 0.
- R11: `lat_adj` is a 20-bit two's-complement value, so a negative trim or an egress time earlier than the ingress time lowers the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| step_en | input | 1 | One-step update enable; low passes the field through |
| ovf_mode | input | 2 | Overflow policy: 00 wrap, 01 clamp, 10 hint-driven, 11 as 00 |
| cf_in | input | 64 | Incoming signed correction field, 2^-16 ns units |
| ts_ingress | input | 48 | Ingress timestamp, 2^-8 ns units, unsigned |
| ts_egress | input | 48 | Egress timestamp, 2^-8 ns units, unsigned |
| lat_adj | input | 20 | Signed latency trim, 2^-8 ns units |
| out_valid | output | 1 | `cf_out` holds a new result |
| cf_out | output | 64 | Updated correction field |

## Verification
The sign assertion for the clamping policy assumes that a non-negative field, an egress time no earlier than the ingress time and a non-negative trim can only overflow upward. It also assumes that the timestamp difference plus the trim, scaled by 256, always fits in 64 bits, which the 48-bit timestamp width guarantees. Random stimulus draws timestamps from the full 48-bit range. It biases the correction field toward both signed limits so that every overflow direction occurs under every mode. The hold and delay assertions assume nothing about how `in_valid` is spaced, so the stimulus mixes isolated pulses with idle cycles in which the operand inputs change.

// File: rtl/cf_updater.sv
module cf_updater #(
  parameter int TS_W  = 48,
  parameter int ADJ_W = 20,
  parameter int CF_W  = 64,
  parameter int SHIFT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            step_en,
  input  logic [1:0]      ovf_mode,
  input  logic [CF_W-1:0] cf_in,
  input  logic [TS_W-1:0] ts_ingress,
  input  logic [TS_W-1:0] ts_egress,
  input  logic [ADJ_W-1:0] lat_adj,
  output logic            out_valid,
  output logic [CF_W-1:0] cf_out
);
  localparam logic [CF_W-1:0] MAX_POS  = {1'b0, {(CF_W-1){1'b1}}};
  localparam logic [CF_W-1:0] MIN_NEG  = {1'b1, {(CF_W-1){1'b0}}};
  localparam logic [CF_W-1:0] LOW_MASK = {{(CF_W-SHIFT){1'b1}}, {SHIFT{1'b0}}};

  logic [TS_W:0]   resid;
  logic [CF_W-1:0] res_ext, adj_ext, delta, cf_op, sum, nxt;
  logic            hint_mode, ovf;

  assign resid     = {1'b0, ts_egress} - {1'b0, ts_ingress};
  assign res_ext   = {{(CF_W-TS_W-1){resid[TS_W]}}, resid};
  assign adj_ext   = {{(CF_W-ADJ_W){lat_adj[ADJ_W-1]}}, lat_adj};
  assign delta     = (res_ext + adj_ext) << SHIFT;
  assign hint_mode = (ovf_mode == 2'b10);
  assign cf_op     = hint_mode ? (cf_in & LOW_MASK) : cf_in;
  assign sum       = cf_op + delta;
  assign ovf       = (cf_op[CF_W-1] == delta[CF_W-1]) && (sum[CF_W-1] != cf_op[CF_W-1]);

  always_comb begin
    nxt = sum;
    if (!step_en) begin
      nxt = cf_in;
    end else begin
      case (ovf_mode)
        2'b01:   if (ovf) nxt = cf_op[CF_W-1] ? MIN_NEG : MAX_POS;
        2'b10: begin
          if (ovf && !cf_in[0]) nxt = cf_in[1] ? MIN_NEG : MAX_POS;
          nxt = nxt & LOW_MASK;
        end
        default: nxt = sum;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cf_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) cf_out <= nxt;
    end
  end
endmodule

// File: rtl/cf_updater_chk.sv
module cf_updater_chk #(
  parameter int TS_W  = 48,
  parameter int ADJ_W = 20,
  parameter int CF_W  = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            step_en,
  input logic [1:0]      ovf_mode,
  input logic [CF_W-1:0] cf_in,
  input logic [TS_W-1:0] ts_ingress,
  input logic [TS_W-1:0] ts_egress,
  input logic [ADJ_W-1:0] lat_adj,
  input logic            out_valid,
  input logic [CF_W-1:0] cf_out
);
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cf_out)); // R9
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !step_en) |=> (cf_out == $past(cf_in))); // R1
  AST_HINT_LOWBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_en && ovf_mode == 2'b10) |=> (cf_out[7:0] == 8'h00)); // R5
  AST_KEEP_LOWBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_en && (ovf_mode == 2'b00 || ovf_mode == 2'b11))
      |=> (cf_out[7:0] == $past(cf_in[7:0]))); // R2
  AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_en && ovf_mode == 2'b01 && !cf_in[CF_W-1] &&
     ts_egress >= ts_ingress && !lat_adj[ADJ_W-1]) |=> !cf_out[CF_W-1]); // R4
endmodule

bind cf_updater cf_updater_chk #(.TS_W(TS_W), .ADJ_W(ADJ_W), .CF_W(CF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_en(step_en),
  .ovf_mode(ovf_mode), .cf_in(cf_in), .ts_ingress(ts_ingress),
  .ts_egress(ts_egress), .lat_adj(lat_adj), .out_valid(out_valid),
  .cf_out(cf_out));

// File: tb/cf_updater_tb_top.sv
module cf_updater_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        step_en = 1'b0;
  logic [1:0]  ovf_mode = 2'b00;
  logic [63:0] cf_in = '0;
  logic [47:0] ts_ingress = '0;
  logic [47:0] ts_egress = '0;
  logic [19:0] lat_adj = '0;
  logic        out_valid;
  logic [63:0] cf_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_updater dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_en(step_en),
    .ovf_mode(ovf_mode), .cf_in(cf_in), .ts_ingress(ts_ingress),
    .ts_egress(ts_egress), .lat_adj(lat_adj), .out_valid(out_valid),
    .cf_out(cf_out));

  function automatic logic [63:0] model(input logic en, input logic [1:0] md,
      input logic [63:0] cf, input logic [47:0] ig, input logic [47:0] eg,
      input logic [19:0] adj);
    logic signed [69:0] a, r, l, e;
    logic ovf;
    logic [63:0] res;
    if (!en) return cf;
    a = (md == 2'b10) ? {{6{cf[63]}}, cf[63:8], 8'h00} : {{6{cf[63]}}, cf};
    r = {22'd0, eg} - {22'd0, ig};
    l = {{50{adj[19]}}, adj};
    e = a + ((r + l) <<< 8);
    ovf = !((e[69:63] == 7'h00) || (e[69:63] == 7'h7F));
    res = e[63:0];
    case (md)
      2'b01: if (ovf) res = e[69] ? MINN : MAXP;
      2'b10: begin
        if (ovf && !cf[0]) res = cf[1] ? MINN : MAXP;
        res[7:0] = 8'h00;
      end
      default: ;
    endcase
    return res;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic en, input logic [1:0] md,
      input logic [63:0] cf, input logic [47:0] ig, input logic [47:0] eg,
      input logic [19:0] adj);
    logic [63:0] exp;
    exp = model(en, md, cf, ig, eg, adj);
    @(negedge clk);
    in_valid = 1'b1; step_en = en; ovf_mode = md; cf_in = cf;
    ts_ingress = ig; ts_egress = eg; lat_adj = adj;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R9 valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, cf_out, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 cf_out", cf_out, 64'd0);
    rst_n = 1'b1;

    run_one("R1 bypass", 1'b0, 2'b01, 64'h7FFF_FFFF_FFFF_FFAB, 48'd5, 48'd900, 20'h7FFFF);
    run_one("R1 bypass hint", 1'b0, 2'b10, 64'h1234_5678_9ABC_DEF3, 48'd1, 48'd2, 20'd0);
    run_one("R2 add", 1'b1, 2'b00, 64'h0000_0000_0001_00CD, 48'd1000, 48'd1500, 20'd20);
    run_one("R3 wrap", 1'b1, 2'b00, 64'h7FFF_FFFF_FFFF_FF00, 48'd7, 48'd8, 20'd0);
    check("R3 literal", cf_out, 64'h8000_0000_0000_0000);
    run_one("R4 sat pos", 1'b1, 2'b01, 64'h7FFF_FFFF_FFFF_FF00, 48'd7, 48'd8, 20'd0);
    check("R4 literal", cf_out, MAXP);
    run_one("R4 sat neg", 1'b1, 2'b01, 64'h8000_0000_0000_0000, 48'd10, 48'd9, 20'd0);
    check("R4 literal neg", cf_out, MINN);
    run_one("R5 low byte", 1'b1, 2'b10, 64'h0000_0000_0000_10FD, 48'd0, 48'd3, 20'd1);
    run_one("R6 hint wrap", 1'b1, 2'b10, 64'h7FFF_FFFF_FFFF_FF01, 48'd0, 48'd1, 20'd0);
    check("R6 literal", cf_out, 64'h8000_0000_0000_0000);
    run_one("R7 hint sat pos", 1'b1, 2'b10, 64'h7FFF_FFFF_FFFF_FF00, 48'd0, 48'd1, 20'd0);
    check("R7 literal", cf_out, 64'h7FFF_FFFF_FFFF_FF00);
    run_one("R7 hint sat neg", 1'b1, 2'b10, 64'h8000_0000_0000_0002, 48'd1, 48'd0, 20'd0);
    check("R7 literal neg", cf_out, MINN);
    run_one("R8 mode3", 1'b1, 2'b11, 64'h7FFF_FFFF_FFFF_FF42, 48'd0, 48'd2, 20'd0);
    run_one("R11 neg adj", 1'b1, 2'b00, 64'h0000_0000_0010_0000, 48'd500, 48'd400, 20'hFFF00);
    check("R11 literal", cf_out, 64'h0000_0000_000F_0000 - 64'd25600 - 64'd65536 + 64'h10000);

    held = cf_out;
    @(negedge clk);
    cf_in = 64'hDEAD_BEEF_0000_0000; step_en = 1'b1; ts_egress = 48'd99;
    @(negedge clk);
    check("R9 idle valid", {63'd0, out_valid}, 64'd0);
    check("R9 hold", cf_out, held);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] cf;
      logic [47:0] ig, eg;
      logic [19:0] adj;
      logic [1:0] md;
      logic en;
      int sel;
      sel = $urandom_range(0, 3);
      cf = {$urandom, $urandom};
      if (sel == 0) cf = MAXP - 64'($urandom_range(0, 1 << 20));
      else if (sel == 1) cf = MINN + 64'($urandom_range(0, 1 << 20));
      ig = {$urandom, $urandom};
      eg = ($urandom_range(0, 1) == 0) ? ig + 48'($urandom_range(0, 5000)) : 48'({$urandom, $urandom});
      adj = 20'($urandom);
      md = 2'($urandom);
      en = ($urandom_range(0, 7) != 0);
      run_one("R2 random", en, md, cf, ig, eg, adj);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule